// File: doc/BRIEF.md
# SAR Conversion Timing Sequencer

This block sequences a single successive-approximation analog-to-digital conversion. A start request names an input channel and picks a short or long sampling window. The sequencer first couples the input to the sample capacitor through a buffer amplifier. It then bypasses the amplifier so that the input charges the capacitor directly. Finally it resolves the result one bit at a time, starting at the most significant bit, by presenting trial codes to the capacitor DAC and reading back a single comparator bit.

All phase timing is counted in ticks of a conversion clock, which is given as a clock enable on the faster system clock. When the conversion finishes, the block returns a 10-bit code and raises a one-cycle completion strobe. A synchronous stop input abandons a conversion at any point. The analog multiplexer, amplifier, DAC and comparator lie outside the block.

Top module: `sar_conv_seq`

## Requirements
- R1: When idle, a start with stop low is accepted on that system clock edge and latches the channel and the sample-select bit. The initial sample phase follows for exactly 2 conversion ticks, with amp_en=1, amp_bypass=0 and sample_en=1.
- R2: The final sample phase follows with amp_en=0, amp_bypass=1 and sample_en=1. It lasts 2 ticks when the latched select bit is 0 and 8 ticks when it is 1.
- R3: The resolution phase lasts 10 ticks and handles one bit per tick, from bit 9 down to bit 0. During the tick for bit b, dac_code holds the bits already decided above b, a 1 at bit b and zeros below b. Bit b is kept at 1 when comp_hi=1 (input at or above the DAC level) and is cleared otherwise.
- R4: eoc is high for exactly one system clock, in the cycle after the edge of the last resolution tick. From that cycle on, result holds the resolved code. Counted from acceptance, a conversion takes 14 ticks with select 0 and 20 ticks with select 1.
- R5: mux_sel carries the accepted channel through the whole conversion and keeps it until the next accepted start.
- R6: The sequencer advances only on edges where qclk_en=1. On other edges every output holds its value.
- R7: A start that arrives while busy=1 is ignored. It changes neither the channel nor the timing.
- R8: stop=1 sends the sequencer to idle on that edge with no eoc, and result keeps its old value. In idle, stop also blocks a start in the same cycle.
- R9: While idle, amp_en, amp_bypass and sample_en are 0, dac_code is 0 and busy is 0.
- R10: After synchronous reset every output is 0.
- R11: result changes only in a cycle where eoc is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| qclk_en | input | 1 | Conversion clock enable, one tick per high cycle |
| start | input | 1 | Conversion request |
| start_chan | input | CH_W (6) | Channel for the request |
| start_long | input | 1 | Final-sample select: 0 gives 2 ticks, 1 gives 8 ticks |
| stop | input | 1 | Synchronous abort |
| comp_hi | input | 1 | Comparator: input at or above the DAC level |
| mux_sel | output | CH_W (6) | Input multiplexer select |
| amp_en | output | 1 | Buffer amplifier enable |
| amp_bypass | output | 1 | Amplifier bypass (direct sampling) |
| sample_en | output | 1 | Sample capacitor connected to the input |
| dac_code | output | RES_W (10) | Trial code for the DAC |
| busy | output | 1 | Conversion in progress |
| eoc | output | 1 | End-of-conversion strobe |
| result | output | RES_W (10) | Last completed code |

## Verification
The bench runs conversions with a steady divide-by-four enable, with the enable held high, and with an irregular enable. A sequencer that counted system clocks instead of ticks would finish early, and the tick-count check would catch it. It checks both sample-select values and target codes at 0, at full scale and at mixed bit patterns. A misplaced trial bit or a wrong keep/clear rule would then show up as a bad dac_code in the per-cycle comparison, or as a bad result. The bench also stops a conversion during resolution, starts again while busy, and raises stop and start together while idle. A design that leaked these cases would pulse eoc, overwrite result, or switch channel in the middle of a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_INIT    = 2'd1,
        PH_FINAL   = 2'd2,
        PH_RESOLVE = 2'd3
    } sar_phase_e;

    typedef struct packed {
        logic amp_en;
        logic bypass;
        logic sample_en;
    } front_ctl_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic sar_phase_e next_phase(input sar_phase_e p);
        case (p)
            PH_INIT:  return PH_FINAL;
            PH_FINAL: return PH_RESOLVE;
            default:  return PH_IDLE;
        endcase
    endfunction

    function automatic front_ctl_t decode_front(input sar_phase_e p);
        front_ctl_t f;
        f.amp_en    = (p == PH_INIT);
        f.bypass    = (p == PH_FINAL);
        f.sample_en = (p == PH_INIT) || (p == PH_FINAL);
        return f;
    endfunction

endpackage

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
    import sar_seq_pkg::*;
#(
    parameter int CH_W        = 6,
    parameter int RES_W       = 10,
    parameter int INIT_TICKS  = 2,
    parameter int FINAL_SHORT = 2,
    parameter int FINAL_LONG  = 8,
    localparam int IDX_W      = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             qclk_en,
    input  logic             start,
    input  logic [CH_W-1:0]  start_chan,
    input  logic             start_long,
    input  logic             stop,
    output sar_phase_e       phase_o,
    output logic [CH_W-1:0]  chan_o,
    output logic             accept_o,
    output logic             res_step_o,
    output logic             res_last_o,
    output logic [IDX_W-1:0] bit_idx_o
);
    localparam int MAX_LEN = max2(max2(INIT_TICKS, FINAL_LONG), max2(FINAL_SHORT, RES_W));
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    sar_phase_e       phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len;
    logic [CH_W-1:0]  chan_q;
    logic             long_q;
    logic             tick;
    logic             phase_end;

    always_comb begin
        case (phase_q)
            PH_INIT:    len = CNT_W'(INIT_TICKS);
            PH_FINAL:   len = long_q ? CNT_W'(FINAL_LONG) : CNT_W'(FINAL_SHORT);
            PH_RESOLVE: len = CNT_W'(RES_W);
            default:    len = CNT_W'(1);
        endcase
    end

    assign tick      = qclk_en && (phase_q != PH_IDLE) && !stop;
    assign phase_end = tick && (cnt_q == len - CNT_W'(1));
    assign accept_o  = (phase_q == PH_IDLE) && start && !stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            chan_q  <= '0;
            long_q  <= 1'b0;
        end else if (stop) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (accept_o) begin
            phase_q <= PH_INIT;
            cnt_q   <= '0;
            chan_q  <= start_chan;
            long_q  <= start_long;
        end else if (tick) begin
            if (phase_end) begin
                phase_q <= next_phase(phase_q);
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign phase_o    = phase_q;
    assign chan_o     = chan_q;
    assign res_step_o = tick && (phase_q == PH_RESOLVE);
    assign res_last_o = res_step_o && phase_end;
    assign bit_idx_o  = IDX_W'(RES_W - 1) - IDX_W'(cnt_q);

endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
    parameter int RES_W  = 10,
    localparam int IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             resolving,
    input  logic             res_step,
    input  logic             res_last,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             comp_hi,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             eoc
);
    logic [RES_W-1:0] sar_q;
    logic [RES_W-1:0] trial;
    logic [RES_W-1:0] decided;
    logic [RES_W-1:0] result_q;
    logic             eoc_q;

    for (genvar i = 0; i < RES_W; i++) begin : g_trial
        assign trial[i] = (bit_idx == IDX_W'(i));
    end

    assign decided  = (sar_q & ~trial) | (comp_hi ? trial : '0);
    assign dac_code = resolving ? (sar_q | trial) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sar_q    <= '0;
            result_q <= '0;
            eoc_q    <= 1'b0;
        end else begin
            eoc_q <= res_last;
            if (clear) begin
                sar_q <= '0;
            end else if (res_step) begin
                sar_q <= decided;
            end
            if (res_last) begin
                result_q <= decided;
            end
        end
    end

    assign result = result_q;
    assign eoc    = eoc_q;

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_seq_pkg::*;
#(
    parameter int CH_W        = 6,
    parameter int RES_W       = 10,
    parameter int INIT_TICKS  = 2,
    parameter int FINAL_SHORT = 2,
    parameter int FINAL_LONG  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             qclk_en,
    input  logic             start,
    input  logic [CH_W-1:0]  start_chan,
    input  logic             start_long,
    input  logic             stop,
    input  logic             comp_hi,
    output logic [CH_W-1:0]  mux_sel,
    output logic             amp_en,
    output logic             amp_bypass,
    output logic             sample_en,
    output logic [RES_W-1:0] dac_code,
    output logic             busy,
    output logic             eoc,
    output logic [RES_W-1:0] result
);
    localparam int IDX_W = $clog2(RES_W);

    sar_phase_e       phase;
    logic             accept;
    logic             res_step;
    logic             res_last;
    logic [IDX_W-1:0] bit_idx;
    front_ctl_t       front;

    sar_phase_ctrl #(
        .CH_W(CH_W), .RES_W(RES_W), .INIT_TICKS(INIT_TICKS),
        .FINAL_SHORT(FINAL_SHORT), .FINAL_LONG(FINAL_LONG)
    ) ctrl_i (
        .clk(clk), .rst(rst), .qclk_en(qclk_en), .start(start),
        .start_chan(start_chan), .start_long(start_long), .stop(stop),
        .phase_o(phase), .chan_o(mux_sel), .accept_o(accept),
        .res_step_o(res_step), .res_last_o(res_last), .bit_idx_o(bit_idx)
    );

    sar_bit_reg #(.RES_W(RES_W)) sar_i (
        .clk(clk), .rst(rst), .clear(accept),
        .resolving(phase == PH_RESOLVE), .res_step(res_step),
        .res_last(res_last), .bit_idx(bit_idx), .comp_hi(comp_hi),
        .dac_code(dac_code), .result(result), .eoc(eoc)
    );

    assign front      = decode_front(phase);
    assign amp_en     = front.amp_en;
    assign amp_bypass = front.bypass;
    assign sample_en  = front.sample_en;
    assign busy       = (phase != PH_IDLE);

endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
    parameter int CH_W  = 6,
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             qclk_en,
    input logic             stop,
    input logic [CH_W-1:0]  mux_sel,
    input logic             amp_en,
    input logic             amp_bypass,
    input logic             sample_en,
    input logic [RES_W-1:0] dac_code,
    input logic             busy,
    input logic             eoc,
    input logic [RES_W-1:0] result
);
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!amp_en && !amp_bypass && !sample_en && dac_code == '0));

    // R2
    front_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(amp_en && amp_bypass));

    // R2
    init_to_final_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(amp_en) && busy) |-> (amp_bypass && sample_en));

    // R4
    eoc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eoc |=> !eoc);

    // R4
    eoc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        eoc |-> !busy);

    // R5
    chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !$rose(busy)) |-> $stable(mux_sel));

    // R6
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !qclk_en && !stop) |=> (busy && $stable(dac_code) && $stable(amp_en)
                                         && $stable(amp_bypass) && !eoc));

    // R8
    stop_abort_chk: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!busy && !eoc && $stable(result)));

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !eoc |-> $stable(result));

endmodule

bind sar_conv_seq sar_conv_seq_chk #(.CH_W(CH_W), .RES_W(RES_W)) chk_i (
    .clk(clk), .rst(rst), .qclk_en(qclk_en), .stop(stop), .mux_sel(mux_sel),
    .amp_en(amp_en), .amp_bypass(amp_bypass), .sample_en(sample_en),
    .dac_code(dac_code), .busy(busy), .eoc(eoc), .result(result)
);

// File: tb/sar_conv_seq_tb_top.sv
module sar_conv_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       qclk_en = 1'b0;
    logic       start = 1'b0;
    logic [5:0] start_chan = '0;
    logic       start_long = 1'b0;
    logic       stop = 1'b0;
    logic       comp_hi;
    logic [5:0] mux_sel;
    logic       amp_en, amp_bypass, sample_en, busy, eoc;
    logic [9:0] dac_code, result;

    logic [9:0] target = '0;
    int         en_mode = 0;   // 0: divide by 4, 1: always high, 2: irregular
    int         dcnt = 0;
    int         total = 0, bad = 0;
    int         tick_cnt = 0;
    bit         chk_on = 1'b0;
    bit         done = 1'b0;

    // reference model state
    bit         m_busy = 0, m_eoc = 0, m_long = 0;
    int         m_ticks = 0;
    logic [5:0] m_chan = '0;
    logic [9:0] m_result = '0;

    always #2.5 clk = ~clk;

    assign comp_hi = (target >= dac_code);

    sar_conv_seq dut_i (
        .clk(clk), .rst(rst), .qclk_en(qclk_en), .start(start),
        .start_chan(start_chan), .start_long(start_long), .stop(stop),
        .comp_hi(comp_hi), .mux_sel(mux_sel), .amp_en(amp_en),
        .amp_bypass(amp_bypass), .sample_en(sample_en), .dac_code(dac_code),
        .busy(busy), .eoc(eoc), .result(result)
    );

    always @(posedge clk) begin
        #1;
        dcnt = dcnt + 1;
        case (en_mode)
            0:       qclk_en = (dcnt % 4 == 3);
            1:       qclk_en = 1'b1;
            default: qclk_en = ($urandom % 3 == 0);
        endcase
    end

    always @(posedge clk) begin
        if (busy && qclk_en && !stop) tick_cnt = tick_cnt + 1;
    end

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_eoc = 0; m_ticks = 0; m_chan = '0; m_result = '0; m_long = 0;
        end else begin
            m_eoc = 0;
            if (!m_busy) begin
                if (start && !stop) begin
                    m_busy = 1; m_ticks = 0; m_chan = start_chan; m_long = start_long;
                end
            end else if (stop) begin
                m_busy = 0;
            end else if (qclk_en) begin
                if (m_ticks == (m_long ? 20 : 14) - 1) begin
                    m_busy = 0; m_eoc = 1; m_result = target;
                end else begin
                    m_ticks = m_ticks + 1;
                end
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) begin
            int f, t, b, e_dac;
            bit e_amp, e_byp, res;
            f = m_long ? 8 : 2;
            t = m_ticks;
            e_amp = m_busy && t < 2;
            e_byp = m_busy && t >= 2 && t < 2 + f;
            res   = m_busy && t >= 2 + f;
            b     = 9 - (t - 2 - f);
            e_dac = res ? ((((int'(target)) >> (b + 1)) << (b + 1)) | (1 << b)) : 0;
            check("R1", "amp_en", int'(amp_en), int'(e_amp));
            check("R2", "amp_bypass", int'(amp_bypass), int'(e_byp));
            check("R2", "sample_en", int'(sample_en), int'(e_amp | e_byp));
            check("R3", "dac_code", int'(dac_code), e_dac);
            check("R9", "busy", int'(busy), int'(m_busy));
            check("R4", "eoc", int'(eoc), int'(m_eoc));
            check("R11", "result", int'(result), int'(m_result));
            check("R5", "mux_sel", int'(mux_sel), int'(m_chan));
        end
    end

    task automatic pulse_start(input logic [5:0] ch, input logic lng);
        @(posedge clk); #1;
        start = 1'b1; start_chan = ch; start_long = lng;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic run_conv(input logic [5:0] ch, input logic lng, input logic [9:0] tgt,
                            input string req);
        int waited;
        @(posedge clk); #1;
        target = tgt;
        tick_cnt = 0;
        pulse_start(ch, lng);
        waited = 0;
        while (!eoc && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        check(req, "eoc seen", int'(eoc), 1);
        check("R4", "tick count", tick_cnt, lng ? 20 : 14);
        check("R3", "result", int'(result), int'(tgt));
        check("R5", "mux_sel", int'(mux_sel), int'(ch));
        @(negedge clk);
        check("R4", "eoc one cycle", int'(eoc), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [9:0] keep;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R10
        check("R10", "reset outputs",
              int'({mux_sel, amp_en, amp_bypass, sample_en, dac_code, busy, eoc, result}), 0);
        chk_on = 1'b1;

        run_conv(6'd5, 1'b0, 10'h2A5, "R1");
        run_conv(6'd63, 1'b1, 10'd1023, "R2");
        run_conv(6'd12, 1'b0, 10'd0, "R3");
        run_conv(6'd1, 1'b1, 10'h155, "R3");

        // R6: enable always high, then irregular enable
        en_mode = 1;
        run_conv(6'd9, 1'b0, 10'h3C0, "R6");
        run_conv(6'd10, 1'b1, 10'h001, "R6");
        en_mode = 2;
        run_conv(6'd33, 1'b1, 10'h2AA, "R6");
        run_conv(6'd34, 1'b0, 10'h200, "R6");
        en_mode = 0;

        // R7: a start while busy is ignored
        fork
            run_conv(6'd3, 1'b0, 10'h0F0, "R7");
            begin
                repeat (12) @(posedge clk);
                #1;
                start = 1'b1; start_chan = 6'd7; start_long = 1'b1;
                @(posedge clk); #1;
                start = 1'b0;
            end
        join
        check("R7", "channel after busy start", int'(mux_sel), 3);

        // R8: stop during resolution
        keep = result;
        target = 10'h3FF;
        pulse_start(6'd20, 1'b1);
        repeat (50) @(posedge clk);
        #1;
        stop = 1'b1;
        @(posedge clk); #1;
        stop = 1'b0;
        @(negedge clk);
        check("R8", "busy after stop", int'(busy), 0);
        begin
            bit saw = 0;
            repeat (120) begin
                @(negedge clk);
                if (eoc) saw = 1;
            end
            check("R8", "no eoc after stop", int'(saw), 0);
        end
        check("R8", "result kept", int'(result), int'(keep));

        // R8: stop and start together while idle
        @(posedge clk); #1;
        start = 1'b1; stop = 1'b1; start_chan = 6'd40;
        @(posedge clk); #1;
        start = 1'b0; stop = 1'b0;
        @(negedge clk);
        check("R8", "stop blocks start", int'(busy), 0);
        // R9
        check("R9", "idle controls", int'({amp_en, amp_bypass, sample_en, dac_code}), 0);

        run_conv(6'd44, 1'b0, 10'h1FF, "R4");

        repeat (4) @(posedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule